// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Selectable Prescalers

The block produces four pulse-width modulated outputs. A small register port sets them up. There are four 16-bit prescaler engines, and each one emits a tick once every `div` input clocks. Each output channel owns an 8-bit position counter that advances on the ticks of one engine. The channel picks that engine through a 2-bit selector. One output period is therefore 256 ticks long, and the output is high while the position is below the channel's duty value.

Software controls the block through three kinds of register:
- A mode register holds a per-channel output enable and a per-channel bypass bit. The bypass bit forces the output high.
- A second mode register gates each channel's position counter.
- Per-engine divider registers and per-channel duty registers set the timing.

New settings act at once. The period in progress is abandoned, not finished. Register reads return the stored contents one clock after the address is presented.

Top module: `quad_pwm`

## Requirements
- R1: After a synchronous reset, every register reads as zero and all four outputs are low.
- R2: Register layout, with byte offsets on a word-aligned bus:
  - 0x00 holds the output enables in bits [3:0] and the bypass bits in bits [11:8], one bit per channel.
  - 0x04 holds the counter enables in bits [3:0].
  - The divider of engine e sits at 0x08+4e in bits [15:0].
  - The duty register of channel c sits at 0x18+4c, with the duty in bits [7:0] and the engine selector in bits [9:8].
  - Unused bits read zero.
  - `rd_data` shows the register addressed on the previous clock.
- R3: A write to an offset that is not word-aligned, or that lies at or above 0x28, changes no register, and a read of such an offset returns zero.
- R4: A channel whose output enable is clear drives its output low, whatever its other settings.
- R5: An enabled channel with its bypass bit set drives its output high, even when its divider is zero or its duty is zero.
- R6: Take an enabled channel with its counter running, bypass clear and its selected divider `div` nonzero. In steady state its output is high for `duty*div` of every `256*div` consecutive clocks.
- R7: A channel's timing follows the divider of the engine its selector names, not the divider of the same index.
- R8: An enabled channel without bypass stays low when its selected divider is zero or its duty is zero.
- R9: While a channel's counter enable is clear, that channel's output stays low unless bypass is set. Setting the enable again resumes normal modulation.
- R10: A write to a divider register restarts that engine and every channel selecting it from position zero. The output of such a channel (duty > 0) is high from the second clock after the write for exactly `duty*div` clocks. A write to a duty register restarts that channel at position zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 6 | Byte offset for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous clock's address |
| pwm_out | output | 4 | Registered channel outputs |

## Verification
The hardest situation to reach from the ports is a channel sharing an engine whose divider is rewritten while the channel is mid-period. The bench reaches it by rewriting the selected divider with its own value right after each steady-state window. It then times the high run that follows. The engine-selection cross is swept fully: every channel against every engine, with four distinct divider values. This way a channel that follows the wrong engine shows up as a wrong high count.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_MODE0,
    KIND_MODE1,
    KIND_DIV,
    KIND_DUTY
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e  kind;
    logic [7:0]  idx;
  } slot_t;

  // Word 0: enables/bypass, word 1: counter enables,
  // words 2..2+n-1: dividers, next n words: duty registers.
  function automatic slot_t decode_slot(input logic [7:0] word, input logic aligned,
                                        input int nch);
    slot_t s;
    int    w;
    w      = int'(word);
    s.kind = KIND_NONE;
    s.idx  = '0;
    if (aligned) begin
      if (w == 0) begin
        s.kind = KIND_MODE0;
      end else if (w == 1) begin
        s.kind = KIND_MODE1;
      end else if (w >= 2 && w < 2 + nch) begin
        s.kind = KIND_DIV;
        s.idx  = 8'(w - 2);
      end else if (w >= 2 + nch && w < 2 + 2 * nch) begin
        s.kind = KIND_DUTY;
        s.idx  = 8'(w - 2 - nch);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DIV_W   = 16,
  parameter int DUTY_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int BYP_LSB = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data,
  output logic [NCH-1:0]                  en_q,
  output logic [NCH-1:0]                  byp_q,
  output logic [NCH-1:0]                  cnt_q,
  output logic [NCH-1:0][DIV_W-1:0]       div_q,
  output logic [NCH-1:0][DUTY_W-1:0]      duty_q,
  output logic [NCH-1:0][$clog2(NCH)-1:0] sel_q,
  output logic [NCH-1:0]                  div_wr,
  output logic [NCH-1:0]                  duty_wr
);

  localparam int SEL_W = $clog2(NCH);

  slot_t             slot;
  logic [SEL_W-1:0]  slot_idx;
  logic [DATA_W-1:0] rd_next;

  assign slot     = decode_slot(8'(addr[ADDR_W-1:2]), addr[1:0] == 2'b00, NCH);
  assign slot_idx = SEL_W'(slot.idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      byp_q  <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      duty_q <= '0;
      sel_q  <= '0;
    end else if (wr_en) begin
      case (slot.kind)
        KIND_MODE0: begin
          for (int c = 0; c < NCH; c++) begin
            en_q[c]  <= wr_data[c];
            byp_q[c] <= wr_data[BYP_LSB+c];
          end
        end
        KIND_MODE1: cnt_q <= wr_data[NCH-1:0];
        KIND_DIV:   div_q[slot_idx] <= wr_data[DIV_W-1:0];
        KIND_DUTY: begin
          duty_q[slot_idx] <= wr_data[DUTY_W-1:0];
          sel_q[slot_idx]  <= wr_data[DUTY_W+SEL_W-1:DUTY_W];
        end
        default: ;
      endcase
    end
  end

  // Restart strobes coincide with the register load.
  always_comb begin
    div_wr  = '0;
    duty_wr = '0;
    if (wr_en && slot.kind == KIND_DIV)  div_wr[slot_idx]  = 1'b1;
    if (wr_en && slot.kind == KIND_DUTY) duty_wr[slot_idx] = 1'b1;
  end

  always_comb begin
    rd_next = '0;
    case (slot.kind)
      KIND_MODE0: begin
        for (int c = 0; c < NCH; c++) begin
          rd_next[c]         = en_q[c];
          rd_next[BYP_LSB+c] = byp_q[c];
        end
      end
      KIND_MODE1: rd_next[NCH-1:0]   = cnt_q;
      KIND_DIV:   rd_next[DIV_W-1:0] = div_q[slot_idx];
      KIND_DUTY: begin
        rd_next[DUTY_W-1:0]              = duty_q[slot_idx];
        rd_next[DUTY_W+SEL_W-1:DUTY_W]   = sel_q[slot_idx];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/pwm_quad_prescaler.sv
module pwm_quad_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;

  assign tick = (div != '0) && (cnt == div - ONE);

  always_ff @(posedge clk) begin
    if (rst || restart || div == '0) cnt <= '0;
    else if (tick)                   cnt <= '0;
    else                             cnt <= cnt + ONE;
  end

endmodule

// File: rtl/pwm_quad_channel.sv
module pwm_quad_channel #(
  parameter int NCH    = 4,
  parameter int DUTY_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ticks,
  input  logic [NCH-1:0]    div_nz,
  input  logic [NCH-1:0]    eng_restart,
  input  logic              duty_wr,
  input  logic              en,
  input  logic              byp,
  input  logic              cnt_en,
  input  logic [DUTY_W-1:0] duty,
  input  logic [SEL_W-1:0]  sel,
  output logic              out
);

  logic [DUTY_W-1:0] pos;
  logic              run;

  assign run = cnt_en && div_nz[sel];

  always_ff @(posedge clk) begin
    if (rst || duty_wr || eng_restart[sel] || !cnt_en) pos <= '0;
    else if (ticks[sel])                               pos <= pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) out <= 1'b0;
    else     out <= en && (byp || (run && (pos < duty)));
  end

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm #(
  parameter int NCH    = 4,
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    pwm_out
);

  localparam int SEL_W = $clog2(NCH);

  logic [NCH-1:0]              en_q;
  logic [NCH-1:0]              byp_q;
  logic [NCH-1:0]              cnt_q;
  logic [NCH-1:0][DIV_W-1:0]   div_q;
  logic [NCH-1:0][DUTY_W-1:0]  duty_q;
  logic [NCH-1:0][SEL_W-1:0]   sel_q;
  logic [NCH-1:0]              div_wr;
  logic [NCH-1:0]              duty_wr;
  logic [NCH-1:0]              ticks;
  logic [NCH-1:0]              div_nz;

  pwm_quad_regs #(
    .NCH(NCH), .DIV_W(DIV_W), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .en_q(en_q), .byp_q(byp_q), .cnt_q(cnt_q),
    .div_q(div_q), .duty_q(duty_q), .sel_q(sel_q),
    .div_wr(div_wr), .duty_wr(duty_wr)
  );

  for (genvar e = 0; e < NCH; e++) begin : g_eng
    assign div_nz[e] = |div_q[e];
    pwm_quad_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst(rst), .restart(div_wr[e]), .div(div_q[e]), .tick(ticks[e])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_quad_channel #(.NCH(NCH), .DUTY_W(DUTY_W), .SEL_W(SEL_W)) u_ch (
      .clk(clk), .rst(rst), .ticks(ticks), .div_nz(div_nz), .eng_restart(div_wr),
      .duty_wr(duty_wr[c]), .en(en_q[c]), .byp(byp_q[c]), .cnt_en(cnt_q[c]),
      .duty(duty_q[c]), .sel(sel_q[c]), .out(pwm_out[c])
    );
  end

endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk #(
  parameter int NCH    = 4,
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8,
  parameter int DATA_W = 32
) (
  input logic                            clk,
  input logic                            rst,
  input logic [DATA_W-1:0]               rd_data,
  input logic [NCH-1:0]                  pwm_out,
  input logic [NCH-1:0]                  en_q,
  input logic [NCH-1:0]                  byp_q,
  input logic [NCH-1:0]                  cnt_q,
  input logic [NCH-1:0][DIV_W-1:0]       div_q,
  input logic [NCH-1:0][DUTY_W-1:0]      duty_q,
  input logic [NCH-1:0][$clog2(NCH)-1:0] sel_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pwm_out == '0 && rd_data == '0));

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:DIV_W] == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic div_zero;
    assign div_zero = (div_q[sel_q[c]] == '0);

    // R4
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(en_q[c]) |-> !pwm_out[c]);

    // R5
    bypass_high_chk: assert property (@(posedge clk) disable iff (rst)
      $past(en_q[c] && byp_q[c]) |-> pwm_out[c]);

    // R8
    div_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!byp_q[c] && div_zero) |-> !pwm_out[c]);

    // R8
    duty_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!byp_q[c] && duty_q[c] == '0) |-> !pwm_out[c]);

    // R9
    counter_off_low_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!byp_q[c] && !cnt_q[c]) |-> !pwm_out[c]);
  end

endmodule

bind quad_pwm quad_pwm_chk #(
  .NCH(NCH), .DIV_W(DIV_W), .DUTY_W(DUTY_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .pwm_out(pwm_out),
  .en_q(en_q), .byp_q(byp_q), .cnt_q(cnt_q),
  .div_q(div_q), .duty_q(duty_q), .sel_q(sel_q)
);

// File: tb/quad_pwm_bench.sv
`timescale 1ns/1ps
module quad_pwm_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  quad_pwm u_quad_pwm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  function automatic logic [5:0] a_div(input int e);
    return 6'(8 + 4 * e);
  endfunction

  function automatic logic [5:0] a_duty(input int c);
    return 6'(24 + 4 * c);
  endfunction

  function automatic int duty_pick(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 37;
      3: return 128;
      default: return 255;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en   = 1'b1;
    addr    = a;
    wr_data = d;
    step();
    wr_en   = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    step();
    d = rd_data;
  endtask

  task automatic count_high(input int ch, input int n, output int hi, output int other);
    hi = 0;
    other = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch]) hi++;
      for (int k = 0; k < 4; k++) if (k != ch && pwm_out[k]) other++;
      step();
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi, oth, run;

    repeat (5) step();
    rst = 1'b0;
    step();

    // R1: reset state
    chk(pwm_out == 4'h0, "R1 outputs", pwm_out, 0);
    for (int r = 0; r < 10; r++) begin
      rd(6'(4 * r), d);
      chk(d == 32'h0, "R1 register", d, 0);
    end

    // R2: write all ones, read back masked values
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h04, 32'hFFFF_FFFF);
    for (int e = 0; e < 4; e++) wr(a_div(e), 32'hFFFF_FFFF);
    for (int c = 0; c < 4; c++) wr(a_duty(c), 32'hFFFF_FFFF);
    rd(6'h00, d); chk(d == 32'h0F0F, "R2 mode0", d, 32'h0F0F);
    rd(6'h04, d); chk(d == 32'h000F, "R2 mode1", d, 32'h000F);
    for (int e = 0; e < 4; e++) begin
      rd(a_div(e), d); chk(d == 32'hFFFF, "R2 divider", d, 32'hFFFF);
    end
    for (int c = 0; c < 4; c++) begin
      rd(a_duty(c), d); chk(d == 32'h03FF, "R2 duty", d, 32'h03FF);
    end
    // distinct values per register
    for (int e = 0; e < 4; e++) wr(a_div(e), 32'h1000 * (e + 1) + 32'h55);
    for (int c = 0; c < 4; c++) wr(a_duty(c), 32'((c << 8) | (16 * c + 3)));
    wr(6'h00, 32'h0000_0A05);
    wr(6'h04, 32'h0000_0006);
    rd(6'h00, d); chk(d == 32'h0A05, "R2 mode0 pattern", d, 32'h0A05);
    rd(6'h04, d); chk(d == 32'h0006, "R2 mode1 pattern", d, 32'h0006);
    for (int e = 0; e < 4; e++) begin
      rd(a_div(e), d);
      chk(d == 32'h1000 * (e + 1) + 32'h55, "R2 divider pattern", d, 32'h1000 * (e + 1) + 32'h55);
    end
    for (int c = 0; c < 4; c++) begin
      rd(a_duty(c), d);
      chk(d == 32'((c << 8) | (16 * c + 3)), "R2 duty pattern", d, (c << 8) | (16 * c + 3));
    end

    // R3: unmapped and misaligned writes ignored
    wr(6'h00, 32'h0);
    wr(6'h04, 32'h0);
    for (int e = 0; e < 4; e++) wr(a_div(e), 32'h0);
    for (int c = 0; c < 4; c++) wr(a_duty(c), 32'h0);
    wr(a_div(0), 32'h1234);
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h01, 32'hFFFF_FFFF);
    wr(6'h0A, 32'hFFFF_FFFF);
    wr(6'h1B, 32'hFFFF_FFFF);
    for (int r = 0; r < 10; r++) begin
      rd(6'(4 * r), d);
      chk(d == ((r == 2) ? 32'h1234 : 32'h0), "R3 register untouched", d, (r == 2) ? 32'h1234 : 0);
    end
    rd(6'h28, d); chk(d == 32'h0, "R3 read unmapped", d, 0);
    rd(6'h09, d); chk(d == 32'h0, "R3 read misaligned", d, 0);
    chk(pwm_out == 4'h0, "R3 outputs", pwm_out, 0);

    // R6 R7 R4 R10: sweep channels x engines x duties, engine e divides by e+1
    for (int e = 0; e < 4; e++) wr(a_div(e), 32'(e + 1));
    wr(6'h04, 32'hF);
    for (int ch = 0; ch < 4; ch++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int di = 0; di < 5; di++) begin
          int dv, dt;
          dv = sel + 1;
          dt = duty_pick(di);
          wr(6'h00, 32'(1 << ch));
          wr(a_duty(ch), 32'((sel << 8) | dt));
          repeat (10) step();
          count_high(ch, 256 * dv, hi, oth);
          chk(hi == dt * dv, "R6 R7 high count", hi, dt * dv);
          chk(oth == 0, "R4 disabled channels", oth, 0);
          if (dt != 0) begin
            wr(a_div(sel), 32'(dv));
            step();
            run = 0;
            while (pwm_out[ch] && run < 2000) begin
              run++;
              step();
            end
            chk(run == dt * dv, "R10 restart run", run, dt * dv);
          end
        end
      end
    end

    // R5: bypass forces high with zero divider and zero duty
    wr(a_div(3), 32'h0);
    wr(a_duty(0), 32'h0300);
    wr(6'h00, 32'h0101);
    repeat (3) step();
    count_high(0, 300, hi, oth);
    chk(hi == 300, "R5 bypass high", hi, 300);
    // R4: bypass without enable stays low
    wr(6'h00, 32'h0100);
    repeat (3) step();
    count_high(0, 300, hi, oth);
    chk(hi == 0, "R4 bypass but disabled", hi, 0);

    // R8: zero divider, nonzero duty
    wr(a_duty(1), 32'h0264);
    wr(a_div(2), 32'h0);
    wr(6'h00, 32'h0002);
    repeat (3) step();
    count_high(1, 300, hi, oth);
    chk(hi == 0, "R8 zero divider", hi, 0);

    // R9: counter gated off, then resumed
    wr(a_div(2), 32'd3);
    wr(6'h04, 32'h0);
    wr(a_duty(1), 32'h02C8);
    repeat (3) step();
    count_high(1, 800, hi, oth);
    chk(hi == 0, "R9 counter off", hi, 0);
    wr(6'h04, 32'h2);
    repeat (10) step();
    count_high(1, 768, hi, oth);
    chk(hi == 600, "R9 counter resumed", hi, 600);

    summary();
    $finish;
  end

endmodule